// File: doc/BRIEF.md
# Instruction Cache Entry Parity Checker

This block examines one instruction-cache entry for parity damage. A request carries the entry's 32-bit upper tag word, its 64-bit lower tag word and the set index. The block checks the tag in one cycle. When data checking is asked for, it then reads the entry's data beats one per cycle through a small read port. Each beat is a 32-bit side word plus two 32-bit instructions. When the walk ends, it reports a one-cycle result. The result carries a tag-parity flag, a data-parity flag, the entry's valid bit and a rebuilt virtual address.

The controller has four states. `ST_IDLE` waits with ready high. A request is accepted only here (transition *accept*). `ST_TAG` holds the evaluated tag results and moves to `ST_BEAT` (transition *walk*) when data checking is on, or to `ST_DONE` (transition *skip*) when it is off. `ST_BEAT` reads one beat per cycle, stays there while beats remain (transition *next*), and moves to `ST_DONE` after the last beat (transition *finish*). `ST_DONE` raises the result strobe for one cycle and returns to `ST_IDLE` (transition *release*).

Top module: `ic_entry_parity_chk`

## Requirements
- R1: After reset, ready is 1, and the result strobe and beat read strobe are 0.
- R2: A request is taken only while ready is 1. A request strobe raised while the block is busy produces no result and changes no result field.
- R3: The valid bit is upper-tag bit 29 and its guard is upper-tag bit 27. If the two differ, the tag error flag is set, whether or not the entry is valid.
- R4: For a valid entry, lower-tag bit 10 must equal the XOR of lower-tag bits 23..0, leaving out bits 11 and 10. A difference sets the tag error flag.
- R5: For a valid entry, lower-tag bit 11 must equal the XOR of lower-tag bits 63..24. A difference sets the tag error flag.
- R6: For an entry whose valid bit is 0, mismatches on lower-tag bits 10 and 11 do not set the tag error flag.
- R7: The reported address keeps lower-tag bits 63..62 and 43..13, clears the others, and ORs in the index. When lower-tag bits 31, 62 and 63 are all 1, bits 61..44 are also set.
- R8: In each beat, side-word bit 16 must equal the XOR of side-word bits 15..8 (the predecode byte). A difference sets the data error flag.
- R9: For each instruction, a 4-bit even parity is formed with one bit per byte, byte 31..24 giving the top bit. Instruction A is compared with side bits 7..4 and instruction B with side bits 3..0. Any difference sets the data error flag.
- R10: With data checking on, exactly NBEATS beat reads occur on consecutive cycles. Read k addresses index + (k << 3), with k running from 0 upward.
- R11: The result strobe is high for exactly one cycle. With data checking off it comes 2 cycles after the accepting edge; with data checking on it comes 2 + NBEATS cycles after it.
- R12: With data checking off, no beat read occurs and the data error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_data_en_i | input | 1 | Enable checking of the data beats |
| req_tag_hi_i | input | 32 | Upper tag word |
| req_tag_lo_i | input | 64 | Lower tag word |
| req_index_i | input | IDX_W | Set index |
| req_ready_o | output | 1 | High while idle |
| beat_rd_o | output | 1 | Beat read strobe |
| beat_addr_o | output | IDX_W | Beat address |
| beat_side_i | input | 32 | Side word for the addressed beat, same cycle |
| beat_insn_a_i | input | 32 | First instruction of the beat |
| beat_insn_b_i | input | 32 | Second instruction of the beat |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_tag_err_o | output | 1 | Tag parity error |
| res_data_err_o | output | 1 | Data parity error |
| res_entry_valid_o | output | 1 | Valid bit of the entry |
| res_va_o | output | 64 | Rebuilt virtual address |

## Verification
For each request, the driver records the cycle of the accepting edge. It then sets the result's due cycle to two cycles later without data beats, and 2 + NBEATS cycles later with them. The monitor samples on the falling edge. It fails any result that arrives off that cycle and any strobe that arrives with nothing expected. Beat reads are expected on the NBEATS falling edges just before the due cycle, and each read address is compared with the index plus the beat offset.

// File: rtl/icpc_pkg.sv
package icpc_pkg;

    localparam int TAG_HI_W = 32;
    localparam int TAG_LO_W = 64;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAG,
        ST_BEAT,
        ST_DONE
    } icpc_state_e;

    // Four-bit even parity, one bit per byte, top byte to top bit.
    function automatic logic [3:0] byte_par4(input logic [WORD_W-1:0] w);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) begin
            p[b] = ^w[8*b +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/ic_tag_check.sv
module ic_tag_check
    import icpc_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic                vbit_i,
    input  logic                vguard_i,
    input  logic [TAG_LO_W-1:0] tag_lo_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic                entry_valid_o,
    output logic                tag_err_o,
    output logic [TAG_LO_W-1:0] va_o
);
    localparam logic [TAG_LO_W-1:0] VA_KEEP  = 64'hC000_0FFF_FFFF_E000;
    localparam logic [TAG_LO_W-1:0] VA_EXT   = 64'h3FFF_F000_0000_0000;
    localparam logic [23:0]         LOW_MASK = 24'hFFF3FF;

    logic low_par, high_par, low_bad, high_bad, guard_bad, ext_en;

    always_comb begin
        low_par   = ^(tag_lo_i[23:0] & LOW_MASK);
        high_par  = ^tag_lo_i[63:24];
        low_bad   = vbit_i && (low_par != tag_lo_i[10]);
        high_bad  = vbit_i && (high_par != tag_lo_i[11]);
        guard_bad = vbit_i ^ vguard_i;
        ext_en    = tag_lo_i[31] && (tag_lo_i[63:62] == 2'b11);

        entry_valid_o = vbit_i;
        tag_err_o     = guard_bad | low_bad | high_bad;
        va_o          = (tag_lo_i & VA_KEEP) | {{(TAG_LO_W-IDX_W){1'b0}}, idx_i};
        if (ext_en) begin
            va_o = va_o | VA_EXT;
        end
    end

    // A guard mismatch alone must always be reported.
    always_comb begin
        if (vbit_i != vguard_i) begin
            AST_GUARD_SEEN: assert (tag_err_o); // R3
        end
    end

endmodule

// File: rtl/ic_beat_check.sv
module ic_beat_check
    import icpc_pkg::*;
#(
    parameter int N_INSN = 2
) (
    input  logic [WORD_W-1:0] side_i,
    input  logic [WORD_W-1:0] insn_a_i,
    input  logic [WORD_W-1:0] insn_b_i,
    output logic              beat_err_o
);
    localparam int PRE_LSB  = 8;
    localparam int PRE_PBIT = 16;

    logic [WORD_W-1:0] insn   [N_INSN];
    logic [N_INSN-1:0] insn_bad;
    logic              pre_bad;
    logic              unused_side_hi;

    assign insn[0] = insn_a_i;
    assign insn[1] = insn_b_i;
    assign unused_side_hi = ^side_i[WORD_W-1:PRE_PBIT+1];

    // Instruction 0 checks against the upper nibble, instruction 1 the lower.
    generate
        for (genvar g = 0; g < N_INSN; g++) begin : g_insn
            localparam int NIB_LSB = 4 * (N_INSN - 1 - g);
            assign insn_bad[g] = (byte_par4(insn[g]) != side_i[NIB_LSB +: 4]);
        end
    endgenerate

    assign pre_bad    = (^side_i[PRE_LSB +: 8]) != side_i[PRE_PBIT];
    assign beat_err_o = pre_bad | (|insn_bad);

endmodule

// File: rtl/ic_entry_parity_chk.sv
module ic_entry_parity_chk
    import icpc_pkg::*;
#(
    parameter int IDX_W      = 13,
    parameter int NBEATS     = 4,
    parameter int BEAT_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_data_en_i,
    input  logic [TAG_HI_W-1:0] req_tag_hi_i,
    input  logic [TAG_LO_W-1:0] req_tag_lo_i,
    input  logic [IDX_W-1:0]    req_index_i,
    output logic                req_ready_o,
    output logic                beat_rd_o,
    output logic [IDX_W-1:0]    beat_addr_o,
    input  logic [WORD_W-1:0]   beat_side_i,
    input  logic [WORD_W-1:0]   beat_insn_a_i,
    input  logic [WORD_W-1:0]   beat_insn_b_i,
    output logic                res_valid_o,
    output logic                res_tag_err_o,
    output logic                res_data_err_o,
    output logic                res_entry_valid_o,
    output logic [TAG_LO_W-1:0] res_va_o
);
    localparam int                 CNT_W     = (NBEATS > 1) ? $clog2(NBEATS) : 1;
    localparam logic [CNT_W-1:0]   LAST_BEAT = CNT_W'(NBEATS - 1);
    localparam logic [IDX_W-1:0]   ADDR_STEP = IDX_W'(1) << BEAT_SHIFT;
    localparam int                 VBIT_POS  = 29;
    localparam int                 VGRD_POS  = 27;

    icpc_state_e state_q, state_d;

    logic                vbit_q, vguard_q, den_q;
    logic [TAG_LO_W-1:0] tag_lo_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    beat_q;
    logic                tag_err_q, valid_q, data_err_q;
    logic [TAG_LO_W-1:0] va_q;

    logic                tc_valid, tc_err;
    logic [TAG_LO_W-1:0] tc_va;
    logic                bc_err;
    logic                unused_tag_hi;

    assign unused_tag_hi = ^{req_tag_hi_i[TAG_HI_W-1:VBIT_POS+1],
                             req_tag_hi_i[VBIT_POS-1:VGRD_POS+1],
                             req_tag_hi_i[VGRD_POS-1:0]};

    ic_tag_check #(.IDX_W(IDX_W)) u_tag (
        .vbit_i        (vbit_q),
        .vguard_i      (vguard_q),
        .tag_lo_i      (tag_lo_q),
        .idx_i         (idx_q),
        .entry_valid_o (tc_valid),
        .tag_err_o     (tc_err),
        .va_o          (tc_va)
    );

    ic_beat_check #(.N_INSN(2)) u_beat (
        .side_i     (beat_side_i),
        .insn_a_i   (beat_insn_a_i),
        .insn_b_i   (beat_insn_b_i),
        .beat_err_o (bc_err)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, walk, skip, next, finish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid_i) state_d = ST_TAG;
            ST_TAG:  state_d = den_q ? ST_BEAT : ST_DONE;
            ST_BEAT: if (beat_q == LAST_BEAT) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready_o       = 1'b0;
        beat_rd_o         = 1'b0;
        res_valid_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready_o = 1'b1;
            ST_TAG:  ;
            ST_BEAT: beat_rd_o   = 1'b1;
            ST_DONE: res_valid_o = 1'b1;
            default: ;
        endcase
        beat_addr_o       = idx_q + (IDX_W'(beat_q) << BEAT_SHIFT);
        res_tag_err_o     = tag_err_q;
        res_data_err_o    = data_err_q;
        res_entry_valid_o = valid_q;
        res_va_o          = va_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbit_q     <= 1'b0;
            vguard_q   <= 1'b0;
            den_q      <= 1'b0;
            tag_lo_q   <= '0;
            idx_q      <= '0;
            beat_q     <= '0;
            tag_err_q  <= 1'b0;
            valid_q    <= 1'b0;
            data_err_q <= 1'b0;
            va_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        vbit_q   <= req_tag_hi_i[VBIT_POS];
                        vguard_q <= req_tag_hi_i[VGRD_POS];
                        den_q    <= req_data_en_i;
                        tag_lo_q <= req_tag_lo_i;
                        idx_q    <= req_index_i;
                    end
                end
                ST_TAG: begin
                    tag_err_q  <= tc_err;
                    valid_q    <= tc_valid;
                    va_q       <= tc_va;
                    data_err_q <= 1'b0;
                    beat_q     <= '0;
                end
                ST_BEAT: begin
                    data_err_q <= data_err_q | bc_err;
                    if (beat_q != LAST_BEAT) begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R11

    AST_SKIP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAG && !den_q) |=> (res_valid_o && !beat_rd_o)); // R11

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rd_o && beat_q != LAST_BEAT) |=>
            (beat_rd_o && beat_addr_o == $past(beat_addr_o) + ADDR_STEP)); // R10

    AST_NO_DATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !den_q) |-> !res_data_err_o); // R12

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready_o && !res_valid_o) |=> $stable(idx_q)); // R2

endmodule

// File: tb/tb_ic_entry_parity_chk.sv
module tb_ic_entry_parity_chk;
    localparam int IDX_W  = 13;
    localparam int NBEATS = 4;

    typedef struct {
        logic        tag_err;
        logic        data_err;
        logic        vbit;
        logic [63:0] va;
        int          due;
        string       rq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_den = 1'b0;
    logic [31:0] req_th = '0;
    logic [63:0] req_tl = '0;
    logic [IDX_W-1:0] req_ix = '0;
    logic req_ready, beat_rd, res_valid, res_terr, res_derr, res_vbit;
    logic [IDX_W-1:0] beat_addr;
    logic [31:0] beat_side, beat_a, beat_b;
    logic [63:0] res_va;

    logic [31:0] m_side [NBEATS];
    logic [31:0] m_a    [NBEATS];
    logic [31:0] m_b    [NBEATS];
    logic [IDX_W-1:0] cur_idx = '0;

    exp_t q[$];
    int cyc = 0, bcnt = 0, n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    ic_entry_parity_chk #(.IDX_W(IDX_W), .NBEATS(NBEATS), .BEAT_SHIFT(3)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_data_en_i(req_den),
        .req_tag_hi_i(req_th), .req_tag_lo_i(req_tl), .req_index_i(req_ix),
        .req_ready_o(req_ready), .beat_rd_o(beat_rd), .beat_addr_o(beat_addr),
        .beat_side_i(beat_side), .beat_insn_a_i(beat_a), .beat_insn_b_i(beat_b),
        .res_valid_o(res_valid), .res_tag_err_o(res_terr), .res_data_err_o(res_derr),
        .res_entry_valid_o(res_vbit), .res_va_o(res_va)
    );

    // Beat memory model: combinational read by offset from the index.
    always_comb begin
        logic [IDX_W-1:0] d;
        d = (beat_addr - cur_idx) >> 3;
        if (d < NBEATS) begin
            beat_side = m_side[d[1:0]];
            beat_a    = m_a[d[1:0]];
            beat_b    = m_b[d[1:0]];
        end else begin
            beat_side = '0; beat_a = '0; beat_b = '0;
        end
    end

    function automatic logic par_range(input logic [63:0] w, input int hi, input int lo);
        logic p = 1'b0;
        for (int i = lo; i <= hi; i++) if (i != 10 && i != 11) p ^= w[i];
        return p;
    endfunction

    function automatic logic [3:0] ipar(input logic [31:0] w);
        logic [3:0] r;
        for (int j = 0; j < 4; j++) begin
            r[j] = 1'b0;
            for (int k = 0; k < 8; k++) r[j] ^= w[8*j+k];
        end
        return r;
    endfunction

    function automatic logic [63:0] fix_tl(input logic [63:0] raw);
        logic [63:0] t = raw;
        t[10] = par_range(raw, 23, 0);
        t[11] = par_range(raw, 63, 24);
        return t;
    endfunction

    function automatic logic [31:0] mk_side(input logic [7:0] pre, input logic [31:0] a,
                                            input logic [31:0] b);
        logic p = 1'b0;
        for (int i = 0; i < 8; i++) p ^= pre[i];
        return {15'd0, p, pre, ipar(a), ipar(b)};
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp_v,
                         input string what);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp_v);
        end
    endtask

    function automatic exp_t model(input logic [31:0] th, input logic [63:0] tl,
                                   input logic [IDX_W-1:0] ix, input logic den);
        exp_t e;
        e.vbit = th[29];
        e.tag_err = th[29] ^ th[27];
        if (th[29]) begin
            if (tl[10] != par_range(tl, 23, 0))  e.tag_err = 1'b1;
            if (tl[11] != par_range(tl, 63, 24)) e.tag_err = 1'b1;
        end
        e.va = '0;
        for (int i = 0; i < 64; i++)
            if ((i >= 13 && i <= 43) || i >= 62) e.va[i] = tl[i];
        e.va = e.va | 64'(ix);
        if (tl[31] && tl[62] && tl[63])
            for (int i = 44; i <= 61; i++) e.va[i] = 1'b1;
        e.data_err = 1'b0;
        if (den) begin
            for (int k = 0; k < NBEATS; k++) begin
                logic p = 1'b0;
                for (int i = 8; i < 16; i++) p ^= m_side[k][i];
                if (p != m_side[k][16]) e.data_err = 1'b1;
                if (ipar(m_a[k]) != m_side[k][7:4]) e.data_err = 1'b1;
                if (ipar(m_b[k]) != m_side[k][3:0]) e.data_err = 1'b1;
            end
        end
        return e;
    endfunction

    // Monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n && beat_rd) begin
            check("R10", 64'(beat_addr), 64'(cur_idx + IDX_W'(bcnt * 8)), "beat address");
            bcnt++;
        end
        if (rst_n && res_valid) begin
            if (q.size() == 0) begin
                check("R2", 64'(1), 64'(0), "unexpected result strobe");
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R11", 64'(cyc), 64'(e.due), "result cycle");
                check(e.rq, 64'(res_terr), 64'(e.tag_err), "tag error");
                check(e.rq, 64'(res_derr), 64'(e.data_err), "data error");
                check("R3", 64'(res_vbit), 64'(e.vbit), "entry valid");
                check("R7", res_va, e.va, "virtual address");
            end
        end
    end

    task automatic send(input logic [31:0] th, input logic [63:0] tl,
                        input logic [IDX_W-1:0] ix, input logic den, input string rq,
                        input logic poke_busy);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        e = model(th, tl, ix, den);
        e.rq = rq;
        e.due = cyc + (den ? 2 + NBEATS : 2);
        cur_idx = ix;
        bcnt = 0;
        q.push_back(e);
        req_valid = 1'b1; req_den = den; req_th = th; req_tl = tl; req_ix = ix;
        @(negedge clk); #1;
        req_valid = 1'b0;
        if (poke_busy) begin
            @(negedge clk); #1;
            req_valid = 1'b1; req_den = 1'b0; req_th = 32'h2800_0000;
            req_tl = 64'hFFFF_0000_0000_FFFF; req_ix = 13'h1FE0;
            @(negedge clk); #1;
            req_valid = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        check(rq, 64'(bcnt), 64'(den ? NBEATS : 0), "beat read count");
    endtask

    task automatic fill_good(input logic [31:0] seed);
        for (int k = 0; k < NBEATS; k++) begin
            m_a[k]    = seed ^ (32'h0101_0101 * (k + 1));
            m_b[k]    = ~seed + 32'(k * 32'h0013_5700);
            m_side[k] = mk_side(8'(seed >> (k * 3)) ^ 8'(k), m_a[k], m_b[k]);
        end
    endtask

    localparam logic [31:0] TH_V = 32'h2800_0000; // valid, guard match
    localparam logic [31:0] TH_I = 32'h0000_0000; // invalid, guard match

    initial begin
        fill_good(32'h1234_5678);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 64'(req_ready), 64'(1), "ready in reset");
        check("R1", 64'(res_valid), 64'(0), "result strobe in reset");
        check("R1", 64'(beat_rd), 64'(0), "beat strobe in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(req_ready), 64'(1), "ready after reset");

        // Clean valid entry, plain address (R4, R5, R7)
        send(TH_V, fix_tl(64'h0000_0A5C_3F2E_6000), 13'h0120, 1'b0, "R4", 1'b0);
        // Guard mismatch on invalid entry (R3)
        send(32'h0800_0000, fix_tl(64'h0000_0123_4567_8000), 13'h0040, 1'b0, "R3", 1'b0);
        // Guard mismatch on valid entry (R3)
        send(32'h2000_0000, fix_tl(64'h0000_0123_4567_8000), 13'h0040, 1'b0, "R3", 1'b0);
        // Invalid entry with both stored bits wrong: ignored (R6)
        send(TH_I, fix_tl(64'h0000_0FED_CBA9_E000) ^ 64'hC00, 13'h1FE0, 1'b0, "R6", 1'b0);
        // Low range mismatch (R4)
        send(TH_V, fix_tl(64'h0000_0777_1234_2000) ^ 64'h400, 13'h0080, 1'b0, "R4", 1'b0);
        // High range mismatch (R5)
        send(TH_V, fix_tl(64'h0000_0777_1234_2000) ^ 64'h800, 13'h0080, 1'b0, "R5", 1'b0);
        // Address extension case (R7)
        send(TH_V, fix_tl(64'hC000_0ABC_8000_4000), 13'h1AE0, 1'b0, "R7", 1'b0);
        // Top bits set but bit 31 clear: no extension (R7)
        send(TH_V, fix_tl(64'hC000_0ABC_0000_4000), 13'h1AE0, 1'b0, "R7", 1'b0);
        // Data beats, all clean (R10, R11)
        send(TH_V, fix_tl(64'h0000_0321_0000_A000), 13'h0260, 1'b1, "R10", 1'b0);
        // Predecode parity broken on beat 2 (R8)
        m_side[2][16] = ~m_side[2][16];
        send(TH_V, fix_tl(64'h0000_0321_0000_A000), 13'h0260, 1'b1, "R8", 1'b0);
        // Instruction A top byte parity broken on beat 1 (R9)
        fill_good(32'h9ABC_DEF0);
        m_side[1][7] = ~m_side[1][7];
        send(TH_V, fix_tl(64'h0000_0111_2222_2000), 13'h0300, 1'b1, "R9", 1'b0);
        // Instruction B lowest byte parity broken on last beat (R9)
        fill_good(32'h0F0F_3C3C);
        m_side[3][0] = ~m_side[3][0];
        send(TH_V, fix_tl(64'h0000_0111_2222_2000), 13'h0300, 1'b1, "R9", 1'b0);
        // Bad data present but checking off: no flag, no reads (R12)
        send(TH_V, fix_tl(64'h0000_0111_2222_2000), 13'h0300, 1'b0, "R12", 1'b0);
        // Request while busy is ignored (R2)
        fill_good(32'h5555_AAAA);
        send(TH_V, fix_tl(64'h0000_0444_0000_6000), 13'h0020, 1'b1, "R2", 1'b1);
        repeat (4) @(negedge clk);
        check("R2", 64'(q.size()), 64'(0), "pending results");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule